// File: doc/BRIEF.md
# Peripheral-to-Pin Priority Crossbar

This block decides which general-purpose pin carries which on-chip peripheral signal. Seventeen peripheral signals have a fixed priority. The pins are three ports of eight bits each. Software writes a per-signal enable vector, an SPI wire-mode bit and one skip mask per port through a small byte-wide register port. The placement logic then hands each enabled signal, in priority order, the lowest-numbered pin that is neither skipped by software nor permanently unavailable.

Because placement depends on priority order rather than on a fixed multiplexer for each pin, enabling or disabling one signal moves every lower-priority signal up or down by one free pin. A pin that carries a special function outside the crossbar must be skipped by software. The crossbar treats such a pin only as a skipped pin. A requested signal that finds no free pin is reported as unplaced.

The pin outputs are purely combinational from the configuration registers, so a register write shows up on the outputs right after the clock edge that captures it.

Top module: `pin_xbar`

## Requirements
- R1: Signal indices, used on `pin_sig`, follow priority from highest to lowest. They are 0 UART TX, 1 UART RX, 2 SPI SCK, 3 SPI MISO, 4 SPI MOSI, 5 SPI NSS, 6 I2C SDA, 7 I2C SCL, 8 comparator out, 9 comparator async out, 10 system clock out, 11–13 PCA channels 0–2, 14 PCA external count input, 15 timer 0 input and 16 timer 1 input.
- R2: Pins are numbered port*8+bit (0..23) and scanned from 0 upward. The k-th requested signal in priority order goes to the k-th free pin.
- R3: A pin whose skip bit is 1 never has `pin_valid` set, and the scan continues past it.
- R4: Pins 16 through 22 (port 2 bits 0–6) are never assigned, whatever their skip bits are. Pin 23 can be assigned.
- R5: A signal whose enable bit is 0 takes no pin, and the lower-priority signals shift down to fill the space.
- R6: SPI NSS (index 5) is requested only when its enable bit is 1 and the wire-mode bit is 1 (4-wire). In 3-wire mode it takes no pin and is not flagged unplaced.
- R7: A requested signal that finds no free pin has its `sig_unplaced` bit set and appears on no pin. The number of valid pins plus the number of unplaced signals equals the number of requested signals.
- R8: The register map has the following addresses, and every register resets to 0:
  - Addresses 0, 1 and 2 hold the skip masks of ports 0, 1 and 2.
  - Address 3 holds enables 7:0.
  - Address 4 holds enables 15:8.
  - Address 5 holds enable 16 in bit 0 and the wire-mode bit in bit 1.
- R9: A write changes the outputs only after the rising clock edge that captures it. Writes to addresses 6 and 7 change nothing.
- R10: A pin with `pin_valid` at 0 drives 0 on its `pin_sig` field, and each valid pin carries an enabled signal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 8 | Register write data |
| pin_valid | output | 24 | Pin n carries a crossbar signal |
| pin_sig | output | 120 | 5-bit signal index per pin, pin n at bits 5n+4..5n |
| sig_unplaced | output | 17 | Requested signal found no free pin |

## Verification
The assertions assume that `cfg_we`, `cfg_addr` and `cfg_wdata` are known and stable around each rising edge. They also assume that the configuration only changes through the write port, so every placement output is a pure function of register contents. The bench drives all inputs on the falling edge and holds the strobe for exactly one rising edge. It applies each configuration as a complete sequence of writes before sampling. Reset is applied only with the write strobe low, so the register-capture checks never see a write that straddles reset.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

  localparam int NUM_SIG = 17;
  localparam int SIG_W   = 5;

  typedef enum logic [SIG_W-1:0] {
    SIG_UART_TX   = 5'd0,
    SIG_UART_RX   = 5'd1,
    SIG_SPI_SCK   = 5'd2,
    SIG_SPI_MISO  = 5'd3,
    SIG_SPI_MOSI  = 5'd4,
    SIG_SPI_NSS   = 5'd5,
    SIG_I2C_SDA   = 5'd6,
    SIG_I2C_SCL   = 5'd7,
    SIG_CMP_OUT   = 5'd8,
    SIG_CMP_ASYNC = 5'd9,
    SIG_SYSCLK    = 5'd10,
    SIG_PCA_CH0   = 5'd11,
    SIG_PCA_CH1   = 5'd12,
    SIG_PCA_CH2   = 5'd13,
    SIG_PCA_ECI   = 5'd14,
    SIG_TMR0_IN   = 5'd15,
    SIG_TMR1_IN   = 5'd16
  } xbar_sig_e;

  localparam int NSS_IDX = int'(SIG_SPI_NSS);

endpackage

// File: rtl/xbar_rst_sync.sv
module xbar_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/xbar_regs.sv
module xbar_regs #(
  parameter int PORTS   = 3,
  parameter int PORT_W  = 8,
  parameter int NUM_SIG = 17,
  parameter int ADDR_W  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [PORT_W-1:0]       wdata,
  output logic [PORTS*PORT_W-1:0] skip_mask,
  output logic [NUM_SIG-1:0]      sig_en,
  output logic                    spi_4w
);

  localparam int PINS      = PORTS * PORT_W;
  localparam int CFG_BITS  = NUM_SIG + 1;
  localparam int CFG_BYTES = (CFG_BITS + PORT_W - 1) / PORT_W;
  localparam int LAST_ADDR = PORTS + CFG_BYTES - 1;

  logic [PINS-1:0]     skip_q, skip_d;
  logic [CFG_BITS-1:0] cfg_q, cfg_d;
  logic                ld_skip, ld_cfg;

  // clock enables
  assign ld_skip = we && (int'(addr) < PORTS);
  assign ld_cfg  = we && (int'(addr) >= PORTS) && (int'(addr) <= LAST_ADDR);

  // next-state
  always_comb begin
    skip_d = skip_q;
    cfg_d  = cfg_q;
    for (int p = 0; p < PORTS; p++) begin
      if (int'(addr) == p) begin
        skip_d[p*PORT_W +: PORT_W] = wdata;
      end
    end
    for (int idx = 0; idx < CFG_BITS; idx++) begin
      if (int'(addr) == PORTS + idx / PORT_W) begin
        cfg_d[idx] = wdata[idx % PORT_W];
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      skip_q <= '0;
    end else if (ld_skip) begin
      skip_q <= skip_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (ld_cfg) begin
      cfg_q <= cfg_d;
    end
  end

  assign skip_mask = skip_q;
  assign sig_en    = cfg_q[NUM_SIG-1:0];
  assign spi_4w    = cfg_q[NUM_SIG];

  // R8 / R9: a port-0 mask write is captured on the edge that sees it
  assert_skip0_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == '0) |=> (skip_q[PORT_W-1:0] == $past(wdata)));

  // R9: writes outside the map leave every register untouched
  assert_unmapped_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (we && int'(addr) > LAST_ADDR) |=> ($stable(skip_q) && $stable(cfg_q)));

  // R8: without a write strobe nothing moves
  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!we) |=> ($stable(skip_q) && $stable(cfg_q)));

endmodule

// File: rtl/xbar_req.sv
module xbar_req #(
  parameter int              NUM_SIG    = 17,
  parameter int              PINS       = 24,
  parameter int              NSS_POS    = 5,
  parameter logic [PINS-1:0] FIXED_SKIP = '0
) (
  input  logic [NUM_SIG-1:0] sig_en,
  input  logic               spi_4w,
  input  logic [PINS-1:0]    skip_mask,
  output logic [NUM_SIG-1:0] req,
  output logic [PINS-1:0]    pin_free
);

  for (genvar s = 0; s < NUM_SIG; s++) begin : g_req
    if (s == NSS_POS) begin : g_nss
      assign req[s] = sig_en[s] & spi_4w;
    end else begin : g_plain
      assign req[s] = sig_en[s];
    end
  end

  assign pin_free = ~(skip_mask | FIXED_SKIP);

endmodule

// File: rtl/xbar_alloc.sv
module xbar_alloc #(
  parameter int NUM_SIG = 17,
  parameter int PINS    = 24,
  parameter int SIG_W   = 5
) (
  input  logic [NUM_SIG-1:0]    req,
  input  logic [PINS-1:0]       pin_free,
  output logic [PINS-1:0]       pin_valid,
  output logic [PINS*SIG_W-1:0] pin_sig,
  output logic [NUM_SIG-1:0]    unplaced
);

  localparam int MAXN  = (PINS > NUM_SIG) ? PINS : NUM_SIG;
  localparam int CNT_W = $clog2(MAXN + 1);

  logic [CNT_W-1:0] sig_rank [NUM_SIG];
  logic [CNT_W-1:0] pin_rank [PINS];
  logic [CNT_W-1:0] nfree;

  // rank of each requested signal among requested signals
  always_comb begin
    logic [CNT_W-1:0] acc;
    acc = '0;
    for (int s = 0; s < NUM_SIG; s++) begin
      sig_rank[s] = acc;
      acc = acc + CNT_W'(req[s]);
    end
  end

  // rank of each free pin among free pins, plus total free count
  always_comb begin
    logic [CNT_W-1:0] acc;
    acc = '0;
    for (int p = 0; p < PINS; p++) begin
      pin_rank[p] = acc;
      acc = acc + CNT_W'(pin_free[p]);
    end
    nfree = acc;
  end

  // each free pin picks the requested signal with matching rank
  for (genvar p = 0; p < PINS; p++) begin : g_pin
    logic             hit;
    logic [SIG_W-1:0] idx;
    always_comb begin
      hit = 1'b0;
      idx = '0;
      for (int s = 0; s < NUM_SIG; s++) begin
        if (pin_free[p] && req[s] && (sig_rank[s] == pin_rank[p])) begin
          hit = 1'b1;
          idx = SIG_W'(s);
        end
      end
    end
    assign pin_valid[p]                = hit;
    assign pin_sig[p*SIG_W +: SIG_W]   = idx;
  end

  for (genvar s = 0; s < NUM_SIG; s++) begin : g_unpl
    assign unplaced[s] = req[s] && (sig_rank[s] >= nfree);
  end

endmodule

// File: rtl/pin_xbar.sv
module pin_xbar
  import xbar_pkg::*;
#(
  parameter int                      PORTS      = 3,
  parameter int                      PORT_W     = 8,
  parameter int                      ADDR_W     = 3,
  parameter logic [PORTS*PORT_W-1:0] FIXED_SKIP = 24'h7F_0000
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [ADDR_W-1:0]             cfg_addr,
  input  logic [PORT_W-1:0]             cfg_wdata,
  output logic [PORTS*PORT_W-1:0]       pin_valid,
  output logic [PORTS*PORT_W*SIG_W-1:0] pin_sig,
  output logic [NUM_SIG-1:0]            sig_unplaced
);

  localparam int PINS = PORTS * PORT_W;

  logic               rst_n_sync;
  logic [PINS-1:0]    skip_mask;
  logic [NUM_SIG-1:0] sig_en;
  logic               spi_4w;
  logic [NUM_SIG-1:0] req;
  logic [PINS-1:0]    pin_free;

  xbar_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  xbar_regs #(
    .PORTS   (PORTS),
    .PORT_W  (PORT_W),
    .NUM_SIG (NUM_SIG),
    .ADDR_W  (ADDR_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .we        (cfg_we),
    .addr      (cfg_addr),
    .wdata     (cfg_wdata),
    .skip_mask (skip_mask),
    .sig_en    (sig_en),
    .spi_4w    (spi_4w)
  );

  xbar_req #(
    .NUM_SIG    (NUM_SIG),
    .PINS       (PINS),
    .NSS_POS    (NSS_IDX),
    .FIXED_SKIP (FIXED_SKIP)
  ) u_req (
    .sig_en    (sig_en),
    .spi_4w    (spi_4w),
    .skip_mask (skip_mask),
    .req       (req),
    .pin_free  (pin_free)
  );

  xbar_alloc #(
    .NUM_SIG (NUM_SIG),
    .PINS    (PINS),
    .SIG_W   (SIG_W)
  ) u_alloc (
    .req       (req),
    .pin_free  (pin_free),
    .pin_valid (pin_valid),
    .pin_sig   (pin_sig),
    .unplaced  (sig_unplaced)
  );

  // observation flags for the placement assertions
  logic nss_on_pin, off_sig_on_pin, idle_pin_nonzero;
  always_comb begin
    nss_on_pin       = 1'b0;
    off_sig_on_pin   = 1'b0;
    idle_pin_nonzero = 1'b0;
    for (int p = 0; p < PINS; p++) begin
      if (pin_valid[p]) begin
        if (int'(pin_sig[p*SIG_W +: SIG_W]) == NSS_IDX) nss_on_pin = 1'b1;
        if (int'(pin_sig[p*SIG_W +: SIG_W]) >= NUM_SIG) off_sig_on_pin = 1'b1;
        else if (!sig_en[pin_sig[p*SIG_W +: SIG_W]]) off_sig_on_pin = 1'b1;
      end else if (pin_sig[p*SIG_W +: SIG_W] != '0) begin
        idle_pin_nonzero = 1'b1;
      end
    end
  end

  assert_skipped_pin_idle_R3: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (pin_valid & skip_mask) == '0);

  assert_fixed_pin_idle_R4: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (pin_valid & FIXED_SKIP) == '0);

  assert_disabled_sig_off_R5: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !off_sig_on_pin);

  assert_nss_needs_4wire_R6: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !spi_4w |-> (!nss_on_pin && !sig_unplaced[NSS_IDX]));

  assert_all_accounted_R7: assert property (@(posedge clk) disable iff (!rst_n_sync)
    ($countones(pin_valid) + $countones(sig_unplaced)) == $countones(req));

  assert_unplaced_only_when_full_R7: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (sig_unplaced != '0) |-> ((pin_valid | ~pin_free) == '1));

  assert_idle_pin_zero_R10: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !idle_pin_nonzero);

endmodule

// File: tb/pin_xbar_bench.sv
`timescale 1ns/1ps
module pin_xbar_bench;

  localparam int            PINS  = 24;
  localparam int            NSIG  = 17;
  localparam int            SW    = 5;
  localparam logic [23:0]   FIXED = 24'h7F_0000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_addr = '0;
  logic [7:0]    cfg_wdata = '0;
  logic [23:0]   pin_valid;
  logic [119:0]  pin_sig;
  logic [16:0]   sig_unplaced;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  pin_xbar u_pin_xbar (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_addr     (cfg_addr),
    .cfg_wdata    (cfg_wdata),
    .pin_valid    (pin_valid),
    .pin_sig      (pin_sig),
    .sig_unplaced (sig_unplaced)
  );

  // {skip0, skip1, skip2, enables, mode, expected valid, expected unplaced}
  localparam int VW = 8 + 8 + 8 + 17 + 1 + 24 + 17;
  localparam int NV = 10;
  localparam logic [VW-1:0] VECS [NV] = '{
    {8'h00, 8'h00, 8'h00, 17'h00000, 1'b0, 24'h000000, 17'h00000},
    {8'h00, 8'h00, 8'h00, 17'h1FFFF, 1'b1, 24'h80FFFF, 17'h00000},
    {8'h00, 8'h00, 8'h00, 17'h1FFFF, 1'b0, 24'h00FFFF, 17'h00000},
    {8'h0C, 8'h03, 8'h00, 17'h1F8FF, 1'b1, 24'h80FCF3, 17'h10000},
    {8'hFF, 8'hFF, 8'h80, 17'h1FFFF, 1'b1, 24'h000000, 17'h1FFFF},
    {8'h01, 8'h00, 8'h7F, 17'h10000, 1'b0, 24'h000002, 17'h00000},
    {8'h00, 8'h00, 8'h00, 17'h00020, 1'b0, 24'h000000, 17'h00000},
    {8'h00, 8'h00, 8'h00, 17'h00020, 1'b1, 24'h000001, 17'h00000},
    {8'h02, 8'h00, 8'h00, 17'h08001, 1'b0, 24'h000005, 17'h00000},
    {8'hFF, 8'hFF, 8'h00, 17'h00003, 1'b1, 24'h800000, 17'h00002}
  };

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic apply(input logic [7:0] s0, s1, s2, input logic [16:0] en, input logic mode);
    wr(3'd0, s0); wr(3'd1, s1); wr(3'd2, s2);
    wr(3'd3, en[7:0]); wr(3'd4, en[15:8]); wr(3'd5, {6'b0, mode, en[16]});
  endtask

  // sequential walk: signals in priority order, pin pointer moves up
  task automatic model(input logic [23:0] skip, input logic [16:0] en, input logic mode,
                       output logic [23:0] v, output logic [119:0] sel, output logic [16:0] un);
    int p;
    v = '0; sel = '0; un = '0; p = 0;
    for (int s = 0; s < NSIG; s++) begin
      if (en[s] && (s != 5 || mode)) begin
        while (p < PINS && (skip[p] || FIXED[p])) p++;
        if (p < PINS) begin
          v[p] = 1'b1; sel[p*SW +: SW] = SW'(s); p++;
        end else begin
          un[s] = 1'b1;
        end
      end
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    logic [23:0]  mv;
    logic [119:0] ms;
    logic [16:0]  mu;
    logic [23:0]  v_before;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R8: reset state
    chk("R8 reset pin_valid", 128'(pin_valid), 128'h0);
    chk("R8 reset sig_unplaced", 128'(sig_unplaced), 128'h0);
    chk("R10 reset pin_sig", 128'(pin_sig), 128'h0);

    for (int i = 0; i < NV; i++) begin
      logic [7:0]  s0, s1, s2;
      logic [16:0] en, eu;
      logic        md;
      logic [23:0] ev;
      {s0, s1, s2, en, md, ev, eu} = VECS[i];
      apply(s0, s1, s2, en, md);
      model({s2, s1, s0}, en, md, mv, ms, mu);
      chk($sformatf("R2/R3/R4/R5/R6 vec%0d pin_valid", i), 128'(pin_valid), 128'(ev));
      chk($sformatf("R7 vec%0d sig_unplaced", i), 128'(sig_unplaced), 128'(eu));
      chk($sformatf("R1/R2/R10 vec%0d pin_sig", i), 128'(pin_sig), 128'(ms));
      if (i == 3) begin
        chk("R3 vec3 pin10 SDA", 128'(pin_sig[10*SW +: SW]), 128'd6);
        chk("R4 vec3 pin23 timer0", 128'(pin_sig[23*SW +: SW]), 128'd15);
        chk("R1 vec3 pin4 SCK", 128'(pin_sig[4*SW +: SW]), 128'd2);
      end
    end

    // R5: drop UART TX from the all-on config; everything shifts down a pin
    apply(8'h00, 8'h00, 8'h00, 17'h1FFFE, 1'b1);
    chk("R5 pin0 carries RX", 128'(pin_sig[4:0]), 128'd1);
    chk("R5 pin15 carries timer1", 128'(pin_sig[15*SW +: SW]), 128'd16);
    chk("R5 pin23 unused", 128'(pin_valid[23]), 128'd0);

    // R9: write visible only after the capturing edge
    apply(8'h00, 8'h00, 8'h00, 17'h00000, 1'b0);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'd3; cfg_wdata = 8'h01;
    #1;
    chk("R9 before edge", 128'(pin_valid), 128'h0);
    @(negedge clk);
    cfg_we = 1'b0;
    chk("R9 after edge", 128'(pin_valid), 128'h1);

    // R9: unmapped addresses change nothing
    v_before = pin_valid;
    wr(3'd6, 8'hFF);
    wr(3'd7, 8'hFF);
    chk("R9 unmapped write pin_valid", 128'(pin_valid), 128'(v_before));
    chk("R9 unmapped write pin_sig", 128'(pin_sig), 128'h0);

    // R8: mid-run reset clears configuration
    apply(8'h00, 8'h00, 8'h00, 17'h1FFFF, 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R8 async reset pin_valid", 128'(pin_valid), 128'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 after reset sig_unplaced", 128'(sig_unplaced), 128'h0);
    chk("R8 after reset pin_valid", 128'(pin_valid), 128'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule